// File: doc/BRIEF.md
# Serial Character Receiver with Line Error Detection

This block recovers asynchronous serial characters from a single input line. A strobe that pulses sixteen times per bit period paces all line sampling. After a falling edge the receiver confirms the start bit at its mid-point. It then samples every data bit, the optional parity bit and the first stop bit once, each at its centre. Each finished character is presented on a one-cycle valid strobe, together with its data and three status flags: parity error, framing error and break.

The framing setup is taken from static configuration inputs: character length of five to eight bits, optional parity of one of four kinds, and a nine-bit mode. In nine-bit mode the ninth received bit is reported in place of the parity flag.

A line held low for a whole character is a break. It is reported as a single zero character with the break flag set, and the receiver then waits for the line to go high before it looks for the next character. After a low stop bit that is not a break, the receiver takes that low sample as the start bit of the following character, so it can regain alignment on a continuous stream.

Top module: `uart_rx_err`

## Requirements
- R1: A falling edge of the line on a strobe begins a start bit, which is checked 8 strobes later. A low sample there confirms the start. A high sample there returns the receiver to idle with no character output.
- R2: cfg_len selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive LSB first and are placed right-aligned in out_data, with the unused upper bits zero. out_valid is a one-cycle pulse for each character.
- R3: With cfg_par_en=1 and cfg_nine=0, one parity bit follows the data. cfg_par_sel selects its kind: 00 odd, 01 even, 10 always 1, 11 always 0. out_perr is 1 when the received bit differs from the expected one. With parity disabled, out_perr is 0.
- R4: With cfg_nine=1, nine data bits are received, and cfg_len and the parity settings are ignored. out_data carries the first eight bits and out_perr carries the ninth.
- R5: If the first stop bit is sampled low and the character is not a break, the character is output with out_ferr=1 and out_brk=0.
- R6: After a framing error, the low stop-bit sample is taken as a confirmed start bit. The next character's bits are sampled every 16 strobes from that point, with no new falling edge needed.
- R7: If the line is sampled low for the start bit, every data bit, the parity bit (when enabled) and the first stop bit, exactly one character is output with out_data=0, out_brk=1, out_ferr=0 and out_perr=0.
- R8: After a break, no character is output while the line stays low. Once the line is sampled high, the next falling edge starts a new character.
- R9: Only the first stop bit is sampled. A new start bit may begin immediately after one stop bit period.
- R10: After reset, out_valid, out_data, out_perr, out_ferr and out_brk are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_sel | input | 2 | Parity kind select |
| cfg_nine | input | 1 | Nine-bit character mode |
| out_valid | output | 1 | One-cycle character strobe |
| out_data | output | 8 | Received data bits |
| out_perr | output | 1 | Parity error, or ninth bit in nine-bit mode |
| out_ferr | output | 1 | Framing error |
| out_brk | output | 1 | Break character |

## Verification
A character's result is due a few cycles after the mid-point strobe of its first stop bit. That delay is the two synchronizer stages, plus up to one strobe interval of phase, plus the output register. The result therefore always arrives before the stop bit period that the driver is holding has ended. The driver queues each expected character before it drives the line. At the end of every sequence it checks that the monitor has drained the queue, so a late or missing result is reported there. Any character that arrives with nothing queued, such as output during a false start or a held break, fails immediately.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_t;

  typedef enum logic [1:0] {
    PK_ODD   = 2'b00,
    PK_EVEN  = 2'b01,
    PK_MARK  = 2'b10,
    PK_SPACE = 2'b11
  } par_kind_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [1:0]    kind,
  output logic          exp_bit
);
  import uart_rx_pkg::*;

  always_comb begin
    unique case (par_kind_t'(kind))
      PK_ODD:   exp_bit = ~(^data);
      PK_EVEN:  exp_bit = ^data;
      PK_MARK:  exp_bit = 1'b1;
      default:  exp_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame #(
  parameter int OVS     = 16,
  parameter int DW      = 8,
  parameter int MIN_LEN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic [1:0]    cfg_par_sel,
  input  logic          cfg_nine,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_perr,
  output logic          out_ferr,
  output logic          out_brk
);
  import uart_rx_pkg::*;

  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DW + 2);

  rx_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   shreg_q;
  logic          zero_q;
  logic          prev_q;
  logic          perr_q;
  logic          exp_par;
  logic [IW-1:0] nbits;
  logic          at_mid;
  logic          use_par;

  assign nbits   = cfg_nine ? IW'(DW + 1) : IW'(MIN_LEN) + IW'(cfg_len);
  assign at_mid  = (cnt_q == CW'(OVS - 1));
  assign use_par = cfg_par_en && !cfg_nine;

  uart_rx_parity #(.DW(DW)) u_par (
    .data    (shreg_q[DW-1:0]),
    .kind    (cfg_par_sel),
    .exp_bit (exp_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      zero_q    <= 1'b0;
      prev_q    <= 1'b1;
      perr_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_brk   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        prev_q <= line;
        unique case (state_q)
          ST_IDLE: begin
            if (prev_q && !line) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_q <= '0;
              if (!line) begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                shreg_q <= '0;
                zero_q  <= 1'b1;
                perr_q  <= 1'b0;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_mid) begin
              cnt_q          <= '0;
              shreg_q[idx_q] <= line;
              zero_q         <= zero_q & ~line;
              if (idx_q == nbits - 1'b1) state_q <= use_par ? ST_PAR : ST_STOP;
              else                       idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              cnt_q   <= '0;
              perr_q  <= (line != exp_par);
              zero_q  <= zero_q & ~line;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_mid) begin
              cnt_q     <= '0;
              out_valid <= 1'b1;
              if (!line && zero_q) begin
                out_data <= '0;
                out_perr <= 1'b0;
                out_ferr <= 1'b0;
                out_brk  <= 1'b1;
                state_q  <= ST_BRK;
              end else begin
                out_data <= shreg_q[DW-1:0];
                out_perr <= cfg_nine ? shreg_q[DW] : perr_q;
                out_ferr <= !line;
                out_brk  <= 1'b0;
                if (line) begin
                  state_q <= ST_IDLE;
                end else begin
                  state_q <= ST_DATA;
                  idx_q   <= '0;
                  shreg_q <= '0;
                  zero_q  <= 1'b1;
                  perr_q  <= 1'b0;
                end
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (line) state_q <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // R2: a character strobe never lasts two cycles
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7: a break character carries zero data and no other flag
  assert_break_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_brk) |-> (out_data == '0 && !out_ferr && !out_perr));

  // R8: nothing is emitted while waiting for the line after a break
  assert_break_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BRK) |=> !out_valid);

  // R1: a high mid-start sample abandons the character
  assert_false_start_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && tick && cnt_q == CW'(HALF - 1) && line)
      |=> (state_q == ST_IDLE && !out_valid));

endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int MIN_LEN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic [1:0]    cfg_par_sel,
  input  logic          cfg_nine,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_perr,
  output logic          out_ferr,
  output logic          out_brk
);
  logic line_s;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  uart_rx_frame #(.OVS(OVS), .DW(DW), .MIN_LEN(MIN_LEN)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick16),
    .line        (line_s),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_sel (cfg_par_sel),
    .cfg_nine    (cfg_nine),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_perr    (out_perr),
    .out_ferr    (out_ferr),
    .out_brk     (out_brk)
  );
endmodule

// File: tb/uart_rx_err_bench.sv
module uart_rx_err_bench;
  localparam int TPS = 4;
  localparam int BITCLK = 16 * TPS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic [1:0] cfg_par_sel = 2'b00;
  logic       cfg_nine = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_perr, out_ferr, out_brk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic perr;
    logic ferr;
    logic brk;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt   <= (tcnt == TPS - 1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TPS - 1);
  end

  uart_rx_err u_uart_rx_err (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
    .cfg_nine(cfg_nine), .out_valid(out_valid), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      n_run++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected character: actual data=%h perr=%b ferr=%b brk=%b expected none",
                 out_data, out_perr, out_ferr, out_brk);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_data !== e.data || out_perr !== e.perr || out_ferr !== e.ferr || out_brk !== e.brk) begin
          n_fail++;
          $display("FAIL %s: actual data=%h perr=%b ferr=%b brk=%b expected data=%h perr=%b ferr=%b brk=%b",
                   e.tag, out_data, out_perr, out_ferr, out_brk, e.data, e.perr, e.ferr, e.brk);
        end
      end
    end
  end

  task automatic expect_ch(input logic [7:0] d, input logic p, input logic f, input logic b, input string tag);
    exp_t e;
    e.data = d; e.perr = p; e.ferr = f; e.brk = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic drive_data(input logic [8:0] d, input int nb);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
  endtask

  task automatic frame(input logic [8:0] d, input int nb, input bit has_par,
                       input logic pbit, input logic stop);
    drive_bit(1'b0);
    drive_data(d, nb);
    if (has_par) drive_bit(pbit);
    drive_bit(stop);
  endtask

  task automatic drained(input string tag);
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual %0d results pending, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] sel);
    case (sel)
      2'b00:   return ~(^d);
      2'b01:   return ^d;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_data !== 8'h00 || out_perr !== 1'b0 ||
        out_ferr !== 1'b0 || out_brk !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: actual v=%b d=%h p=%b f=%b b=%b expected all zero",
               out_valid, out_data, out_perr, out_ferr, out_brk);
    end
    drive_bit(1'b1); drive_bit(1'b1);

    // R2: 8-bit characters, no parity
    expect_ch(8'hA5, 0, 0, 0, "R2 len8 A5"); frame(9'h0A5, 8, 0, 0, 1);
    expect_ch(8'h3C, 0, 0, 0, "R2 len8 3C"); frame(9'h03C, 8, 0, 0, 1);
    drive_bit(1'b1); drained("R2 len8 timing");

    // R2: shorter lengths, upper bits zero
    cfg_len = 2'b00; expect_ch(8'h15, 0, 0, 0, "R2 len5"); frame(9'h0F5, 5, 0, 0, 1);
    cfg_len = 2'b01; expect_ch(8'h2A, 0, 0, 0, "R2 len6"); frame(9'h0EA, 6, 0, 0, 1);
    cfg_len = 2'b10; expect_ch(8'h7F, 0, 0, 0, "R2 len7"); frame(9'h0FF, 7, 0, 0, 1);
    drive_bit(1'b1); drained("R2 short timing");

    // R3: parity kinds, correct and wrong
    cfg_len = 2'b11; cfg_par_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      logic [7:0] d;
      d = 8'h5B + 8'(s * 17);
      cfg_par_sel = 2'(s);
      expect_ch(d, 0, 0, 0, "R3 parity good");
      frame({1'b0, d}, 8, 1, par_of(d, 2'(s)), 1);
      expect_ch(d, 1, 0, 0, "R3 parity bad");
      frame({1'b0, d}, 8, 1, ~par_of(d, 2'(s)), 1);
      drive_bit(1'b1); drained("R3 timing");
    end

    // R4: nine-bit mode ignores length and parity
    cfg_nine = 1'b1; cfg_len = 2'b00;
    expect_ch(8'hA5, 1, 0, 0, "R4 ninth bit 1"); frame(9'h1A5, 9, 0, 0, 1);
    expect_ch(8'h5A, 0, 0, 0, "R4 ninth bit 0"); frame(9'h05A, 9, 0, 0, 1);
    drive_bit(1'b1); drained("R4 timing");
    cfg_nine = 1'b0; cfg_len = 2'b11; cfg_par_en = 1'b0;

    // R5 and R6: bad stop then resync on it as start bit
    expect_ch(8'h55, 0, 1, 0, "R5 framing error");
    frame(9'h055, 8, 0, 0, 0);
    expect_ch(8'h81, 0, 0, 0, "R6 resync char");
    drive_data(9'h081, 8); drive_bit(1'b1);
    drive_bit(1'b1); drained("R6 timing");

    // R1: false start glitch, then normal character
    rxd = 1'b0; repeat (3 * TPS) @(negedge clk);
    drive_bit(1'b1); drive_bit(1'b1);
    drained("R1 false start silent");
    expect_ch(8'h42, 0, 0, 0, "R1 after glitch"); frame(9'h042, 8, 0, 0, 1);
    drive_bit(1'b1); drained("R1 timing");

    // R7 and R8: break with parity on, held low, then recovery
    cfg_par_en = 1'b1; cfg_par_sel = 2'b01;
    expect_ch(8'h00, 0, 0, 1, "R7 break");
    for (int i = 0; i < 24; i++) drive_bit(1'b0);
    drained("R8 single break while low");
    drive_bit(1'b1);
    expect_ch(8'h99, 0, 0, 0, "R8 after break"); frame(9'h099, 8, 1, par_of(8'h99, 2'b01), 1);
    drive_bit(1'b1); drained("R8 timing");

    // R7 boundary: zero data, high parity bit, low stop -> framing not break
    cfg_par_sel = 2'b00;
    expect_ch(8'h00, 0, 1, 0, "R7 not break when parity high");
    frame(9'h000, 8, 1, 1'b1, 0);
    expect_ch(8'hFF, 0, 0, 0, "R6 resync on idle high");
    drive_data(9'h0FF, 8); drive_bit(1'b1); drive_bit(1'b1);
    drive_bit(1'b1); drained("R6 idle resync timing");
    cfg_par_en = 1'b0;

    // R9: back-to-back characters with single stop
    expect_ch(8'h12, 0, 0, 0, "R9 first"); frame(9'h012, 8, 0, 0, 1);
    expect_ch(8'h34, 0, 0, 0, "R9 second"); frame(9'h034, 8, 0, 0, 1);
    drive_bit(1'b1); drained("R9 timing");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule